// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the device side of a single-data-rate SDRAM command bus. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank select, the address bus and the byte mask. It turns each sample into a command code and keeps the mode word from the last load-mode command. It also records which of four banks holds an open row, and it counts the beats of the read or write burst in progress.

From that state it produces per-byte write-enable strobes and read output-enable strobes. The write mask acts in the cycle it is sampled. The read mask acts two cycles after it is sampled, and the read strobes themselves follow the programmed CAS latency. A level flag reports a reserved mode word. A sticky flag reports commands that break the row protocol. The block is meant to sit beside a memory model or a bus monitor, where it supplies the command view, the row view and the data-strobe view that the memory array itself would act on.

Every output is a register that updates on the edge where the command is sampled.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: `cmd_o` reports the command sampled at the previous edge. The codes are 0 no-op, 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge, 6 auto refresh, 7 self-refresh entry and 8 load mode. They come from {row,col,wr} strobes 111, 011, 101, 100, 110, 010, 001 and 000 with chip select low. With chip select high the cycle reports 0 and changes no state, whatever the other pins are.
- R2: Strobe pattern 001 with clock enable high is auto refresh (code 6) and changes no state. With clock enable low it is self-refresh entry (code 7) and raises `self_ref_o`. While `self_ref_o` is high every sample reports 0 and is ignored. The first edge that samples clock enable high clears `self_ref_o`, and that sample is ignored as well.
- R3: An activate to a closed bank sets bit `bank_sel` of `bank_open_o`. An activate to a bank that is already open leaves the row state unchanged.
- R4: A precharge with `addr[10]` high closes all banks and ignores `bank_sel`. With `addr[10]` low it closes only bank `bank_sel`. A read or write with `addr[10]` high closes its bank on the edge of its final beat, but only if that burst is not cut short. A read or write with `addr[10]` low leaves its bank open.
- R5: A load mode stores `addr[11:0]`. Bits [2:0] set the burst length: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, 7 gives a full page of 2^COL_W beats, and the reserved codes give 1 beat. Bit 9 high turns writes into single-beat accesses, while reads keep the programmed length.
- R6: A read or write to an open bank starts a burst. The first beat falls on the command edge and the rest on the following edges. `beat_o` is high after every beat edge. A burst stop sampled during a burst ends it without a beat on that edge. A new legal read or write cuts the running burst short and starts its own.
- R7: After a write beat edge, `wr_en_o` equals the inverse of the byte mask sampled on that same edge. After any other edge it is 0.
- R8: A read beat on edge t makes `rd_oe_o` equal, after edge t+CL, to the inverse of the byte mask sampled at edge t+CL-2. CL is 3 when mode bits [6:4] hold 3, and 2 otherwise. Outside read data slots `rd_oe_o` is 0.
- R9: `mode_err_o` is high while the stored mode word has a nonzero value in bits [8:7], a burst code of 4, 5 or 6, or a CAS latency field other than 2 or 3.
- R10: `proto_err_o` is set by a read or write to a closed bank and by an activate to an open bank, and stays set until reset. A read or write to a closed bank starts no burst and leaves a running burst untouched.
- R11: Synchronous reset clears all outputs and row state and loads a mode word of 1-beat bursts, CAS latency 2 and normal writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| clk_en | input | 1 | Clock enable |
| bank_sel | input | BA_W | Bank select |
| addr | input | ADDR_W | Address / mode op-code bus |
| bmask | input | MASK_W | Byte mask, high masks a byte lane |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | NBANK | One bit per bank, high when a row is open |
| beat_o | output | 1 | A burst beat fell on the last edge |
| wr_en_o | output | MASK_W | Per-byte write enable for the last beat |
| rd_oe_o | output | MASK_W | Per-byte read output enable for the current data slot |
| self_ref_o | output | 1 | Self refresh in effect |
| mode_err_o | output | 1 | Stored mode word is reserved |
| proto_err_o | output | 1 | Sticky row-protocol violation |

## Verification
A wrong beat counter shows up as `beat_o` and `wr_en_o` staying high one edge too long or dropping one edge too early, so the error is visible on the very edge where the count goes wrong. A wrong row bit is visible in `bank_open_o` at once. Its knock-on effects appear later: `proto_err_o` rises on the next access to that bank, and when the row bit was left set by a missed auto-precharge, `proto_err_o` rises on the next activate to that bank. A wrong read-pipeline slot or a wrong mask history shifts `rd_oe_o` by whole cycles, and this shows two or three edges after the read beat that caused it. A bench model that is compared on every edge catches each of these on the first differing cycle.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_STOP = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_AREF = 4'd6,
    CMD_SREF = 4'd7,
    CMD_LMR  = 4'd8
  } cmd_e;

  // Field positions decoded from the mode word and the address bus
  localparam int MODE_W   = 12;
  localparam int AP_BIT   = 10;
  localparam int WB_BIT   = 9;
  localparam int OPM_HI   = 8;
  localparam int OPM_LO   = 7;
  localparam int CL_HI    = 6;
  localparam int CL_LO    = 4;
  localparam int BL_HI    = 2;
  localparam int BL_LO    = 0;

  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    logic opm_bad, bl_bad, cl_bad;
    opm_bad = (m[OPM_HI:OPM_LO] != 2'b00);
    bl_bad  = (m[BL_HI:BL_LO] inside {3'd4, 3'd5, 3'd6});
    cl_bad  = !(m[CL_HI:CL_LO] inside {3'd2, 3'd3});
    return opm_bad | bl_bad | cl_bad;
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_pkg::*;
(
  input  logic chip_sel_n,
  input  logic row_strobe_n,
  input  logic col_strobe_n,
  input  logic wr_strobe_n,
  input  logic clk_en,
  output cmd_e cmd
);

  always_comb begin
    if (chip_sel_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({row_strobe_n, col_strobe_n, wr_strobe_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_STOP;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = clk_en ? CMD_AREF : CMD_SREF;
        default: cmd = CMD_LMR;
      endcase
    end
  end

endmodule

// File: rtl/sdr_bank_state.sv
module sdr_bank_state #(
  parameter int NBANK = 4,
  parameter int BA_W  = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_en,
  input  logic [BA_W-1:0]  act_bank,
  input  logic             pre_en,
  input  logic             pre_all,
  input  logic [BA_W-1:0]  pre_bank,
  input  logic             ap_en,
  input  logic [BA_W-1:0]  ap_bank,
  output logic [NBANK-1:0] open_q
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic set_g, clr_g;
    assign set_g = act_en && (act_bank == BA_W'(g));
    assign clr_g = (ap_en && (ap_bank == BA_W'(g))) ||
                   (pre_en && (pre_all || (pre_bank == BA_W'(g))));

    always_ff @(posedge clk) begin
      if (rst)        open_q[g] <= 1'b0;
      else if (set_g) open_q[g] <= 1'b1;
      else if (clr_g) open_q[g] <= 1'b0;
    end
  end

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_en && pre_all && !act_en) |=> (open_q == '0));

  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    act_en |=> open_q[$past(act_bank)]);

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl #(
  parameter int COL_W  = 9,
  parameter int MASK_W = 8,
  parameter int BA_W   = 2,
  parameter int CNT_W  = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic              start_ap,
  input  logic [BA_W-1:0]   start_bank,
  input  logic [CNT_W-1:0]  len,
  input  logic              stop,
  input  logic              cl3,
  input  logic [MASK_W-1:0] bmask,
  output logic              beat_q,
  output logic [MASK_W-1:0] wr_en_q,
  output logic [MASK_W-1:0] rd_oe_q,
  output logic              ap_en,
  output logic [BA_W-1:0]   ap_bank
);

  localparam int MAX_CL  = 3;
  localparam int MASK_LAT = 2;

  logic [CNT_W-1:0]  rem_q, rem_nxt;
  logic              cur_wr_q, cur_ap_q;
  logic [BA_W-1:0]   cur_bank_q;
  logic [MAX_CL-1:0] rhist_q;
  logic [MASK_W-1:0] mhist_q [MASK_LAT];
  logic              active, beat, kind_wr, wbeat, rbeat, slot;

  always_comb begin
    active  = (rem_q != '0);
    beat    = start | (active & ~stop);
    kind_wr = start ? start_wr : cur_wr_q;
    if (start)       rem_nxt = len - 1'b1;
    else if (stop)   rem_nxt = '0;
    else if (active) rem_nxt = rem_q - 1'b1;
    else             rem_nxt = '0;
    ap_en   = beat & (rem_nxt == '0) & (start ? start_ap : cur_ap_q);
    ap_bank = start ? start_bank : cur_bank_q;
    wbeat   = beat & kind_wr;
    rbeat   = beat & ~kind_wr;
    slot    = cl3 ? rhist_q[MAX_CL-1] : rhist_q[MAX_CL-2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q      <= '0;
      cur_wr_q   <= 1'b0;
      cur_ap_q   <= 1'b0;
      cur_bank_q <= '0;
      rhist_q    <= '0;
      beat_q     <= 1'b0;
      wr_en_q    <= '0;
      rd_oe_q    <= '0;
      for (int i = 0; i < MASK_LAT; i++) mhist_q[i] <= '0;
    end else begin
      rem_q   <= rem_nxt;
      if (start) begin
        cur_wr_q   <= start_wr;
        cur_ap_q   <= start_ap;
        cur_bank_q <= start_bank;
      end
      rhist_q    <= {rhist_q[MAX_CL-2:0], rbeat};
      mhist_q[0] <= bmask;
      for (int i = 1; i < MASK_LAT; i++) mhist_q[i] <= mhist_q[i-1];
      beat_q  <= beat;
      wr_en_q <= wbeat ? ~bmask : '0;
      rd_oe_q <= slot ? ~mhist_q[MASK_LAT-1] : '0;
    end
  end

  // R6
  stop_end_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> (rem_q == '0));

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !stop && !start) |=> (rem_q == $past(rem_q) - 1'b1));

  // R7
  wr_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q != '0) |-> beat_q);

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
  import sdr_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int MASK_W = 8,
  parameter int BA_W   = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_strobe_n,
  input  logic              clk_en,
  input  logic [BA_W-1:0]   bank_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] bmask,
  output logic [3:0]        cmd_o,
  output logic [NBANK-1:0]  bank_open_o,
  output logic              beat_o,
  output logic [MASK_W-1:0] wr_en_o,
  output logic [MASK_W-1:0] rd_oe_o,
  output logic              self_ref_o,
  output logic              mode_err_o,
  output logic              proto_err_o
);

  localparam int CNT_W = COL_W + 1;
  localparam logic [CNT_W-1:0] FULL_PAGE = CNT_W'(1) << COL_W;
  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(12'h020);

  cmd_e              cmd_raw, cmd_eff, cmd_q;
  logic [MODE_W-1:0] mode_q, mode_nxt;
  logic              self_ref_q, proto_err_q, mode_err_q;
  logic [NBANK-1:0]  open_q;
  logic              bank_is_open, is_rw, rw_ok, is_act, act_ok, err_now;
  logic [CNT_W-1:0]  len, bl_len;
  logic              ap_en;
  logic [BA_W-1:0]   ap_bank;
  logic              unused_bits;

  assign unused_bits = ^{addr[ADDR_W-1:MODE_W], mode_q[3], mode_q[MODE_W-1:AP_BIT]};

  sdr_cmd_decode u_dec (
    .chip_sel_n   (chip_sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_strobe_n  (wr_strobe_n),
    .clk_en       (clk_en),
    .cmd          (cmd_raw)
  );

  always_comb begin
    cmd_eff      = self_ref_q ? CMD_NOP : cmd_raw;
    bank_is_open = open_q[bank_sel];
    is_rw        = (cmd_eff == CMD_RD) || (cmd_eff == CMD_WR);
    is_act       = (cmd_eff == CMD_ACT);
    rw_ok        = is_rw & bank_is_open;
    act_ok       = is_act & ~bank_is_open;
    err_now      = (is_rw & ~bank_is_open) | (is_act & bank_is_open);
    mode_nxt     = (cmd_eff == CMD_LMR) ? addr[MODE_W-1:0] : mode_q;
    unique case (mode_q[BL_HI:BL_LO])
      3'd0:    bl_len = CNT_W'(1);
      3'd1:    bl_len = CNT_W'(2);
      3'd2:    bl_len = CNT_W'(4);
      3'd3:    bl_len = CNT_W'(8);
      3'd7:    bl_len = FULL_PAGE;
      default: bl_len = CNT_W'(1);
    endcase
    len = ((cmd_eff == CMD_WR) && mode_q[WB_BIT]) ? CNT_W'(1) : bl_len;
  end

  sdr_bank_state #(.NBANK(NBANK), .BA_W(BA_W)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .act_en   (act_ok),
    .act_bank (bank_sel),
    .pre_en   (cmd_eff == CMD_PRE),
    .pre_all  (addr[AP_BIT]),
    .pre_bank (bank_sel),
    .ap_en    (ap_en),
    .ap_bank  (ap_bank),
    .open_q   (open_q)
  );

  sdr_burst_ctrl #(.COL_W(COL_W), .MASK_W(MASK_W), .BA_W(BA_W), .CNT_W(CNT_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .start      (rw_ok),
    .start_wr   (cmd_eff == CMD_WR),
    .start_ap   (addr[AP_BIT]),
    .start_bank (bank_sel),
    .len        (len),
    .stop       (cmd_eff == CMD_STOP),
    .cl3        (mode_q[CL_HI:CL_LO] == 3'd3),
    .bmask      (bmask),
    .beat_q     (beat_o),
    .wr_en_q    (wr_en_o),
    .rd_oe_q    (rd_oe_o),
    .ap_en      (ap_en),
    .ap_bank    (ap_bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= CMD_NOP;
      mode_q      <= MODE_RST;
      mode_err_q  <= 1'b0;
      self_ref_q  <= 1'b0;
      proto_err_q <= 1'b0;
    end else begin
      cmd_q       <= cmd_eff;
      mode_q      <= mode_nxt;
      mode_err_q  <= mode_reserved(mode_nxt);
      self_ref_q  <= self_ref_q ? ~clk_en : (cmd_raw == CMD_SREF);
      proto_err_q <= proto_err_q | err_now;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_open_o = open_q;
  assign self_ref_o  = self_ref_q;
  assign mode_err_o  = mode_err_q;
  assign proto_err_o = proto_err_q;

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err_q |=> proto_err_q);

  // R2
  sref_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (self_ref_q && $past(self_ref_q)) |-> (cmd_q == CMD_NOP));

  // R9
  mode_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_LMR) |-> $stable(mode_err_q));

endmodule

// File: tb/sdr_cmd_tracker_tb.sv
module sdr_cmd_tracker_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        sel_n = 1'b1, rs_n = 1'b1, cs_n = 1'b1, ws_n = 1'b1, cke = 1'b1;
  logic [1:0]  bsel = '0;
  logic [12:0] addr = '0;
  logic [7:0]  bm = 8'hFF;

  logic [3:0] cmd_o, open_o;
  logic       beat_o, sref_o, merr_o, perr_o;
  logic [7:0] wr_o, rd_o;

  sdr_cmd_tracker u_dut (
    .clk(clk), .rst(rst), .chip_sel_n(sel_n), .row_strobe_n(rs_n),
    .col_strobe_n(cs_n), .wr_strobe_n(ws_n), .clk_en(cke), .bank_sel(bsel),
    .addr(addr), .bmask(bm), .cmd_o(cmd_o), .bank_open_o(open_o),
    .beat_o(beat_o), .wr_en_o(wr_o), .rd_oe_o(rd_o), .self_ref_o(sref_o),
    .mode_err_o(merr_o), .proto_err_o(perr_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m_open [4];
  bit         m_sref, m_perr, m_wr, m_ap;
  logic [11:0] m_mode;
  int         m_rem, m_bank, cyc;
  bit         rd_slot [int];
  logic [7:0] bm_log [int];
  logic [3:0] e_cmd, e_open;
  logic [7:0] e_wr, e_rd;
  bit         e_beat, e_merr;

  function automatic int bl_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic bit bad_mode(input logic [11:0] m);
    return (m[8:7] != 0) || (m[2:0] == 4) || (m[2:0] == 5) || (m[2:0] == 6) ||
           ((m[6:4] != 2) && (m[6:4] != 3));
  endfunction

  always @(posedge clk) begin : model
    int c, cl, close_b;
    bit started, act_ok, beat;
    cyc++;
    bm_log[cyc] = bm;
    if (rst) begin
      foreach (m_open[i]) m_open[i] = 0;
      m_sref = 0; m_perr = 0; m_wr = 0; m_ap = 0; m_rem = 0; m_bank = 0;
      m_mode = 12'h020;
      rd_slot.delete();
      e_cmd = 0; e_open = 0; e_wr = 0; e_rd = 0; e_beat = 0; e_merr = 0;
    end else begin
      c = 0;
      if (m_sref) begin
        if (cke) m_sref = 0;
      end else if (!sel_n) begin
        case ({rs_n, cs_n, ws_n})
          3'b111: c = 0;
          3'b011: c = 1;
          3'b101: c = 2;
          3'b100: c = 3;
          3'b110: c = 4;
          3'b010: c = 5;
          3'b001: begin c = cke ? 6 : 7; if (!cke) m_sref = 1; end
          default: c = 8;
        endcase
      end
      started = ((c == 2) || (c == 3)) && m_open[bsel];
      act_ok  = (c == 1) && !m_open[bsel];
      if (((c == 2) || (c == 3)) && !m_open[bsel]) m_perr = 1;
      if ((c == 1) && m_open[bsel]) m_perr = 1;
      cl = (m_mode[6:4] == 3) ? 3 : 2;
      if (started) begin
        m_rem  = (c == 3 && m_mode[9]) ? 1 : bl_of(m_mode[2:0]);
        m_wr   = (c == 3);
        m_ap   = addr[10];
        m_bank = bsel;
      end else if (c == 4) begin
        m_rem = 0;
      end
      beat = 0; close_b = -1;
      if (m_rem > 0) begin
        beat = 1;
        m_rem--;
        if (m_rem == 0 && m_ap) close_b = m_bank;
      end
      e_wr = (beat && m_wr) ? ~bm : 8'h00;
      if (beat && !m_wr) rd_slot[cyc + cl] = 1;
      e_rd = (rd_slot.exists(cyc) && bm_log.exists(cyc - 2)) ? ~bm_log[cyc - 2] : 8'h00;
      if (close_b >= 0) m_open[close_b] = 0;
      if (c == 5) begin
        if (addr[10]) foreach (m_open[i]) m_open[i] = 0;
        else m_open[bsel] = 0;
      end
      if (act_ok) m_open[bsel] = 1;
      if (c == 8) m_mode = addr[11:0];
      e_cmd  = c[3:0];
      e_open = {m_open[3], m_open[2], m_open[1], m_open[0]};
      e_beat = beat;
      e_merr = bad_mode(m_mode);
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      chk("R1 cmd", cmd_o, e_cmd);
      chk("R3/R4 rows", open_o, e_open);
      chk("R6 beat", beat_o, e_beat);
      chk("R7 wr_en", wr_o, e_wr);
      chk("R8 rd_oe", rd_o, e_rd);
      chk("R2 self_ref", sref_o, m_sref);
      chk("R9 mode_err", merr_o, e_merr);
      chk("R10 proto_err", perr_o, m_perr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic s, input logic [2:0] p, input logic k,
                       input logic [1:0] b, input logic [12:0] a, input logic [7:0] m);
    sel_n = s; {rs_n, cs_n, ws_n} = p; cke = k; bsel = b; addr = a; bm = m;
    @(negedge clk);
  endtask

  task automatic nop(input logic [7:0] m = 8'hFF); issue(0, 3'b111, 1, 0, 0, m); endtask
  task automatic act(input logic [1:0] b); issue(0, 3'b011, 1, b, 13'h0, 8'hFF); endtask
  task automatic rd(input logic [1:0] b, input logic ap, input logic [7:0] m);
    issue(0, 3'b101, 1, b, ap ? 13'h400 : 13'h0, m);
  endtask
  task automatic wr(input logic [1:0] b, input logic ap, input logic [7:0] m);
    issue(0, 3'b100, 1, b, ap ? 13'h400 : 13'h0, m);
  endtask
  task automatic stop_b(); issue(0, 3'b110, 1, 0, 0, 8'hFF); endtask
  task automatic pre(input logic [1:0] b, input logic all);
    issue(0, 3'b010, 1, b, all ? 13'h400 : 13'h0, 8'hFF);
  endtask
  task automatic lmr(input logic [11:0] v); issue(0, 3'b000, 1, 0, {1'b0, v}, 8'hFF); endtask
  task automatic do_reset(); rst = 1; nop(); nop(); rst = 0; endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 rows", open_o, 4'h0);
    chk("R11 cmd", cmd_o, 4'h0);
    chk("R11 mode_err", merr_o, 0);
    chk("R11 proto_err", perr_o, 0);
    chk("R11 wr_en", wr_o, 8'h00);

    lmr(12'h022);
    chk("R5 load valid mode", merr_o, 0);
    act(0); act(2);
    chk("R3 two rows open", open_o, 4'b0101);
    wr(0, 0, 8'h00);  chk("R7 beat0 mask", wr_o, 8'hFF);
    nop(8'h0F);       chk("R7 beat1 mask", wr_o, 8'hF0);
    nop(8'hF0);       chk("R7 beat2 mask", wr_o, 8'h0F);
    nop(8'hFF);       chk("R7 beat3 mask", wr_o, 8'h00);
    nop();            chk("R6 burst over", beat_o, 0);
    rd(2, 0, 8'h00);
    nop(8'h3C);
    nop(8'hFF);       chk("R8 cl2 slot0", rd_o, 8'hFF);
    nop();            chk("R8 cl2 slot1", rd_o, 8'hC3);
    nop(); nop(); nop();
    act(0);           chk("R10 act on open row", perr_o, 1);
    chk("R3 row state kept", open_o, 4'b0101);
    nop();            chk("R10 sticky", perr_o, 1);
    do_reset();

    lmr(12'h222);
    act(1);
    wr(1, 0, 8'h00);
    nop();            chk("R5 single write", beat_o, 0);
    rd(1, 1, 8'h00);
    nop(); nop(); nop(); nop();
    chk("R4 auto precharge", open_o, 4'b0000);
    act(1); rd(1, 0, 8'h00); nop();
    wr(1, 0, 8'h00);  chk("R6 truncating write", wr_o, 8'hFF);
    nop();            chk("R6 truncated read ends", beat_o, 0);
    nop(); nop(); nop();
    lmr(12'h022);
    rd(1, 0, 8'hFF); nop();
    stop_b();         chk("R6 stop no beat", beat_o, 0);
    nop();            chk("R6 stop ended", beat_o, 0);
    repeat (4) nop();
    lmr(12'h032);
    rd(1, 0, 8'hFF);
    nop(8'h00);
    nop();            chk("R8 cl3 not yet", rd_o, 8'h00);
    nop();            chk("R8 cl3 slot0", rd_o, 8'hFF);
    repeat (6) nop();
    lmr(12'h037);
    rd(1, 0, 8'h00);
    repeat (9) nop();
    chk("R5 full page still running", beat_o, 1);
    stop_b();         chk("R6 full page stopped", beat_o, 0);
    repeat (5) nop();

    lmr(12'h0A2);     chk("R9 reserved op mode", merr_o, 1);
    lmr(12'h025);     chk("R9 reserved length", merr_o, 1);
    lmr(12'h012);     chk("R9 reserved latency", merr_o, 1);
    lmr(12'h022);     chk("R9 valid again", merr_o, 0);

    act(0); act(3);
    chk("R3 rows", open_o, 4'b1011);
    pre(3, 0);        chk("R4 single precharge", open_o, 4'b0011);
    pre(2, 1);        chk("R4 all precharge", open_o, 4'b0000);

    act(2);
    issue(0, 3'b001, 1, 1, 13'h1FFF, 8'h00);
    chk("R2 auto refresh code", cmd_o, 4'd6);
    chk("R2 refresh ignores mask", wr_o, 8'h00);
    chk("R2 refresh keeps rows", open_o, 4'b0100);
    issue(0, 3'b001, 0, 0, 13'h0, 8'hFF);
    chk("R2 self refresh code", cmd_o, 4'd7);
    chk("R2 self refresh flag", sref_o, 1);
    issue(0, 3'b011, 0, 1, 13'h0, 8'hFF);
    chk("R2 act ignored", open_o, 4'b0100);
    issue(0, 3'b000, 0, 0, 13'h0A2, 8'hFF);
    chk("R2 load ignored", merr_o, 0);
    issue(0, 3'b011, 1, 1, 13'h0, 8'hFF);
    chk("R2 exit", sref_o, 0);
    chk("R2 exit sample ignored", open_o, 4'b0100);

    issue(1, 3'b000, 1, 0, 13'h0A2, 8'hFF);
    chk("R1 deselect nop", cmd_o, 4'd0);
    chk("R1 deselect no load", merr_o, 0);
    rd(3, 0, 8'h00);
    chk("R1 read code", cmd_o, 4'd2);
    chk("R10 read closed bank", perr_o, 1);
    do_reset();

    lmr(12'h033);
    for (int n = 0; n < 400; n++) begin
      logic [2:0] p;
      int pick;
      pick = $urandom_range(0, 11);
      case (pick)
        0, 1:    p = 3'b011;
        2, 3:    p = 3'b101;
        4, 5:    p = 3'b100;
        6:       p = 3'b110;
        7:       p = 3'b010;
        8:       p = 3'b001;
        default: p = 3'b111;
      endcase
      issue(($urandom_range(0, 7) == 0), p, ($urandom_range(0, 5) != 0),
            2'($urandom_range(0, 3)), 13'($urandom()), 8'($urandom()));
    end
    repeat (4) nop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule